// File: doc/BRIEF.md
# Stereo PWM Audio Sample Pacer

This block sets the pace of a two-channel PWM audio path. Two small sample queues, one per side, are filled through a write strobe and a data bus. A 12-bit cycle setting sets the PWM period. The block reloads the left and right output levels from the queues once per period, and the level stays constant between reloads. Each output channel has a 2-bit route mode. The mode makes the channel read its own queue, read the opposite queue, or stay silent and hold its last level. A one-cycle frame strobe marks the start of every period.

At each reload the block records, as single flag bits inside 16-bit status words, whether each queue is now empty. It also records whether both queues are empty. A 4-bit count of the periods that carried a reload raises an interrupt to two processors after a programmable number of such periods. Under the control of an enable bit, the same event also pulses a DMA request to both processors. Each interrupt is held until that processor acknowledges it.

Top module: `pwm_sample_pacer`

## Requirements
- R1: With cycle setting C (12-bit), the period is (C-1) mod 4096 clocks, so C=0 gives 4095. frame_strobe pulses once per period, and consecutive pulses are exactly that many clocks apart. A reload updates left_level and right_level in the same cycle that frame_strobe is high.
- R2: With C=1 the period is zero. No frame_strobe occurs, no sample is consumed and the levels do not change.
- R3: left_mode encoding: 1 loads left_level from the left queue, 2 loads it from the right queue. With 0 or 3 the left channel takes nothing and left_level holds.
- R4: right_mode encoding: 1 loads right_level from the right queue, 2 loads it from the left queue. With 0 or 3 the right channel takes nothing and right_level holds.
- R5: A reload happens only in a period where at least one mode is 1 or 2. In any other period no queue entry is consumed, the status words hold and the period count does not advance.
- R6: When both channels read the same queue in one period, the left channel takes the oldest entry and the right channel takes the next one. A channel whose queue has no entry left for it keeps its previous level.
- R7: Each queue holds 3 samples of 12 bits and returns them oldest first. A write to a full queue is dropped.
- R8: After each reload, bit 14 of left_stat is 1 exactly when the left queue is empty, and bit 14 of right_stat does the same for the right queue. Bit 14 of mono_stat is the AND of the two. All other bits are 0. Between reloads all three words hold.
- R9: After reset: all three status words read 0x4000, both levels are 0, and frame_strobe, irq and dreq are 0. Both queues are empty.
- R10: The interrupt to both processors is raised after every T reload periods, where T is the timer field (1..15) and 0 stands for 16. irq is seen in the same cycle as the frame_strobe of the T-th reload.
- R11: irq[i] stays high until irq_ack[i] is high for a cycle. An acknowledge clears only its own bit, and a new event in the same cycle as an acknowledge wins.
- R12: On each interrupt event both dreq bits pulse for exactly one cycle if dreq_en is 1. They stay 0 if dreq_en is 0.
- R13: A timer_wr pulse clears the period count, and the T periods of R10 are counted from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_cfg | input | 12 | PWM cycle setting; period is this value minus one |
| left_mode | input | 2 | Left channel route mode |
| right_mode | input | 2 | Right channel route mode |
| timer_cfg | input | 4 | Reload periods per interrupt (0 means 16) |
| timer_wr | input | 1 | Pulse: timer field written, clears the period count |
| dreq_en | input | 1 | Enables the DMA request pulse on interrupt events |
| lfifo_wr | input | 1 | Write strobe for the left queue |
| lfifo_data | input | 12 | Sample written to the left queue |
| rfifo_wr | input | 1 | Write strobe for the right queue |
| rfifo_data | input | 12 | Sample written to the right queue |
| irq_ack | input | 2 | Per-processor interrupt acknowledge |
| left_level | output | 12 | Current left output level |
| right_level | output | 12 | Current right output level |
| frame_strobe | output | 1 | One-cycle pulse at the start of each period |
| left_stat | output | 16 | Left status word, bit 14 = left queue empty |
| right_stat | output | 16 | Right status word, bit 14 = right queue empty |
| mono_stat | output | 16 | Combined status word, bit 14 = both queues empty |
| irq | output | 2 | Interrupt to each processor |
| dreq | output | 2 | DMA request pulse to each processor |

## Verification
The bench uses the default parameters: 3-entry queues, 12-bit samples, a 12-bit cycle setting and a 4-bit timer field. With queues this shallow, a few writes reach the full and drop case, and the double-read case with too few entries is easy to set up. The bench runs every pairing of left and right mode twice, with varying fill counts, against a queue model of its own. Because the timer field has only 4 bits, all sixteen interrupt intervals are swept. The cycle setting is tested at its wrap-around value 0, and also at 1 and several small values.

// File: rtl/pwm_pace_pkg.sv
// Package: shared constants, route type and helpers for the PWM sample pacer.
// Assumes the status word carries its empty flag at bit 14.
package pwm_pace_pkg;

    localparam logic [1:0] MODE_STRAIGHT = 2'd1;
    localparam logic [1:0] MODE_CROSSED  = 2'd2;
    localparam int         STAT_W        = 16;
    localparam int         EMPTY_BIT     = 14;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LFIFO = 2'd1,
        SRC_RFIFO = 2'd2
    } src_e;

    // Left channel: straight reads the left queue, crossed reads the right one.
    function automatic src_e route_left(input logic [1:0] mode);
        case (mode)
            MODE_STRAIGHT: return SRC_LFIFO;
            MODE_CROSSED:  return SRC_RFIFO;
            default:       return SRC_NONE;
        endcase
    endfunction

    // Right channel: straight reads the right queue, crossed reads the left one.
    function automatic src_e route_right(input logic [1:0] mode);
        case (mode)
            MODE_STRAIGHT: return SRC_RFIFO;
            MODE_CROSSED:  return SRC_LFIFO;
            default:       return SRC_NONE;
        endcase
    endfunction

    // Build a status word with only the empty flag placed.
    function automatic logic [STAT_W-1:0] stat_word(input logic empty);
        logic [STAT_W-1:0] w;
        w            = '0;
        w[EMPTY_BIT] = empty;
        return w;
    endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
// Module: small sample queue with head and second-entry visibility.
// Up to two entries can be popped in one cycle. A pop larger than the fill
// level takes only what is there. A push is accepted when room remains after
// the pop in the same cycle, and is dropped otherwise.
// Assumes DEPTH >= 2.
module pwm_sample_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic [1:0]                   pop_req,
    output logic [W-1:0]                 head,
    output logic [W-1:0]                 second,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty_after
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem     [DEPTH];
    logic [W-1:0]     mem_nxt [DEPTH];
    logic [CNT_W-1:0] pop_eff;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] cnt_nxt;
    logic             push_ok;

    // Work out how many entries leave and whether the push fits.
    always_comb begin
        pop_eff     = (CNT_W'(pop_req) > level) ? level : CNT_W'(pop_req);
        remain      = level - pop_eff;
        push_ok     = push && (remain < CNT_W'(DEPTH));
        cnt_nxt     = remain + CNT_W'(push_ok);
        empty_after = (cnt_nxt == '0);
    end

    // Per-slot next value: shift by the pop amount, then place the push.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] sh1;
        logic [W-1:0] sh2;
        if (g + 1 < DEPTH) begin : g_s1
            assign sh1 = mem[g+1];
        end else begin : g_z1
            assign sh1 = '0;
        end
        if (g + 2 < DEPTH) begin : g_s2
            assign sh2 = mem[g+2];
        end else begin : g_z2
            assign sh2 = '0;
        end
        assign mem_nxt[g] = (push_ok && remain == CNT_W'(g)) ? push_data :
                            (pop_eff == '0)                  ? mem[g]    :
                            (pop_eff == CNT_W'(1))           ? sh1       : sh2;
    end

    // Storage and fill level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            level <= cnt_nxt;
            mem   <= mem_nxt;
        end
    end

    assign head   = mem[0];
    assign second = mem[1];

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH) && push && pop_req == 2'd0) |=> level == CNT_W'(DEPTH));

endmodule

// File: rtl/pwm_period_timer.sv
// Module: PWM period timer. It produces a one-cycle tick at the last clock of
// each period. The period is cycle_cfg minus one (modulo 2**CYCLE_W); zero
// means idle. If the setting shrinks below the current count, the next cycle
// ends the period.
module pwm_period_timer #(
    parameter int CYCLE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CYCLE_W-1:0] cycle_cfg,
    output logic               tick
);
    logic [CYCLE_W-1:0] period;
    logic [CYCLE_W-1:0] pcnt;

    // Derive the period length and decide when it ends.
    always_comb begin
        period = cycle_cfg - CYCLE_W'(1);
        tick   = (period != '0) && (pcnt >= period - CYCLE_W'(1));
    end

    // Clock counter within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pcnt <= '0;
        else if (tick || period == '0)    pcnt <= '0;
        else                              pcnt <= pcnt + CYCLE_W'(1);
    end

    assert_count_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cycle_cfg) && period != '0) |-> pcnt < period);

endmodule

// File: rtl/pwm_event_counter.sv
// Module: counts reload periods. Every timer_cfg of them (0 meaning
// 2**TIMER_W) it raises a held interrupt and, if enabled, a one-cycle DMA
// request to each processor. A timer write clears the count and suppresses
// counting in that cycle.
module pwm_event_counter #(
    parameter int TIMER_W = 4,
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_period,
    input  logic [TIMER_W-1:0] timer_cfg,
    input  logic               timer_wr,
    input  logic               dreq_en,
    input  logic [NUM_CPU-1:0] irq_ack,
    output logic [NUM_CPU-1:0] irq,
    output logic [NUM_CPU-1:0] dreq
);
    logic [TIMER_W-1:0] periods;
    logic               rollover;

    // Event when the count reaches the timer field minus one.
    always_comb begin
        rollover = active_period && !timer_wr &&
                   (periods == timer_cfg - TIMER_W'(1));
    end

    // Reload-period count.
    always_ff @(posedge clk) begin
        if (!rst_n)                    periods <= '0;
        else if (timer_wr || rollover) periods <= '0;
        else if (active_period)        periods <= periods + TIMER_W'(1);
    end

    // DMA request pulse toward all processors.
    always_ff @(posedge clk) begin
        if (!rst_n) dreq <= '0;
        else        dreq <= {NUM_CPU{rollover && dreq_en}};
    end

    // Held interrupt per processor; a new event beats the acknowledge.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n)          irq[c] <= 1'b0;
            else if (rollover)   irq[c] <= 1'b1;
            else if (irq_ack[c]) irq[c] <= 1'b0;
        end
    end

    assert_irq_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !irq_ack[0]) |=> irq[0]);

    assert_dreq_with_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dreq[0] |-> irq[0]);

    assert_dreq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dreq_en) |-> dreq == '0);

    assert_timer_write_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        timer_wr |=> dreq == '0);

endmodule

// File: rtl/pwm_sample_pacer.sv
// Module: stereo PWM sample pacer (top). It routes queue samples to the two
// channel levels once per PWM period according to each route mode, keeps the
// empty-status words and drives the period-count interrupt and DMA request.
// Assumes the host bus has already decoded writes into the strobes below.
module pwm_sample_pacer
    import pwm_pace_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int FIFO_DEPTH = 3,
    parameter int CYCLE_W    = 12,
    parameter int TIMER_W    = 4,
    parameter int NUM_CPU    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CYCLE_W-1:0]  cycle_cfg,
    input  logic [1:0]          left_mode,
    input  logic [1:0]          right_mode,
    input  logic [TIMER_W-1:0]  timer_cfg,
    input  logic                timer_wr,
    input  logic                dreq_en,
    input  logic                lfifo_wr,
    input  logic [SAMPLE_W-1:0] lfifo_data,
    input  logic                rfifo_wr,
    input  logic [SAMPLE_W-1:0] rfifo_data,
    input  logic [NUM_CPU-1:0]  irq_ack,
    output logic [SAMPLE_W-1:0] left_level,
    output logic [SAMPLE_W-1:0] right_level,
    output logic                frame_strobe,
    output logic [STAT_W-1:0]   left_stat,
    output logic [STAT_W-1:0]   right_stat,
    output logic [STAT_W-1:0]   mono_stat,
    output logic [NUM_CPU-1:0]  irq,
    output logic [NUM_CPU-1:0]  dreq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    logic                tick;
    src_e                lsrc;
    src_e                rsrc;
    logic                chan_on;
    logic                fetch;
    logic [1:0]          lpop;
    logic [1:0]          rpop;
    logic [SAMPLE_W-1:0] lnext;
    logic [SAMPLE_W-1:0] rnext;
    logic [SAMPLE_W-1:0] lf_head, lf_second, rf_head, rf_second;
    logic [CNT_W-1:0]    lf_cnt, rf_cnt;
    logic                lf_empty_after, rf_empty_after;
    logic                lempty_q, rempty_q, mempty_q;
    logic                strobe_q;

    pwm_period_timer #(.CYCLE_W(CYCLE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_cfg (cycle_cfg),
        .tick      (tick)
    );

    pwm_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_lfifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (lfifo_wr),
        .push_data   (lfifo_data),
        .pop_req     (lpop),
        .head        (lf_head),
        .second      (lf_second),
        .level       (lf_cnt),
        .empty_after (lf_empty_after)
    );

    pwm_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (rfifo_wr),
        .push_data   (rfifo_data),
        .pop_req     (rpop),
        .head        (rf_head),
        .second      (rf_second),
        .level       (rf_cnt),
        .empty_after (rf_empty_after)
    );

    pwm_event_counter #(.TIMER_W(TIMER_W), .NUM_CPU(NUM_CPU)) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_period (fetch),
        .timer_cfg     (timer_cfg),
        .timer_wr      (timer_wr),
        .dreq_en       (dreq_en),
        .irq_ack       (irq_ack),
        .irq           (irq),
        .dreq          (dreq)
    );

    // Route decision: the left channel reads first, the right channel takes what is left.
    always_comb begin
        lsrc    = route_left(left_mode);
        rsrc    = route_right(right_mode);
        chan_on = (lsrc != SRC_NONE) || (rsrc != SRC_NONE);
        fetch   = tick && chan_on;
        lpop    = 2'd0;
        rpop    = 2'd0;
        lnext   = left_level;
        rnext   = right_level;
        if (fetch) begin
            case (lsrc)
                SRC_LFIFO: begin
                    lpop = lpop + 2'd1;
                    if (lf_cnt != '0) lnext = lf_head;
                end
                SRC_RFIFO: begin
                    rpop = rpop + 2'd1;
                    if (rf_cnt != '0) lnext = rf_head;
                end
                default: ;
            endcase
            case (rsrc)
                SRC_RFIFO: begin
                    if (rpop == 2'd0) begin
                        if (rf_cnt != '0) rnext = rf_head;
                    end else if (rf_cnt >= CNT_W'(2)) begin
                        rnext = rf_second;
                    end
                    rpop = rpop + 2'd1;
                end
                SRC_LFIFO: begin
                    if (lpop == 2'd0) begin
                        if (lf_cnt != '0) rnext = lf_head;
                    end else if (lf_cnt >= CNT_W'(2)) begin
                        rnext = lf_second;
                    end
                    lpop = lpop + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // Output level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_level  <= '0;
            right_level <= '0;
        end else begin
            left_level  <= lnext;
            right_level <= rnext;
        end
    end

    // Empty-status flags, refreshed only on a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lempty_q <= 1'b1;
            rempty_q <= 1'b1;
            mempty_q <= 1'b1;
        end else if (fetch) begin
            lempty_q <= lf_empty_after;
            rempty_q <= rf_empty_after;
            mempty_q <= lf_empty_after & rf_empty_after;
        end
    end

    // Frame strobe marking the first cycle of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= tick;
    end

    assign frame_strobe = strobe_q;
    assign left_stat    = stat_word(lempty_q);
    assign right_stat   = stat_word(rempty_q);
    assign mono_stat    = stat_word(mempty_q);

    assert_unit_cycle_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cycle_cfg == CYCLE_W'(1)) |-> !frame_strobe);

    assert_left_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch) |-> $stable(left_level));

    assert_right_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch) |-> $stable(right_level));

    assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch) |-> ($stable(mono_stat) && $stable(left_stat)));

endmodule

// File: tb/pwm_sample_pacer_bench.sv
module pwm_sample_pacer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cyc = 12'd1;
    logic [1:0]  lm = 2'd0, rm = 2'd0;
    logic [3:0]  tmr = 4'd0;
    logic        twr = 1'b0, den = 1'b0;
    logic        lwr = 1'b0, rwr = 1'b0;
    logic [11:0] ld = '0, rd = '0;
    logic [1:0]  ack = 2'b00;
    logic [11:0] left_level, right_level;
    logic        frame_strobe;
    logic [15:0] left_stat, right_stat, mono_stat;
    logic [1:0]  irq, dreq;

    int total = 0;
    int bad = 0;
    int wd = 0;

    int ql[3], qr[3];
    int cl = 0, cr = 0;
    int exp_l = 0, exp_r = 0, exp_ls = 16384, exp_rs = 16384, exp_ms = 16384;
    int seq = 1000;

    always #4 clk = ~clk;

    pwm_sample_pacer u_pwm_sample_pacer (
        .clk(clk), .rst_n(rst_n), .cycle_cfg(cyc), .left_mode(lm), .right_mode(rm),
        .timer_cfg(tmr), .timer_wr(twr), .dreq_en(den),
        .lfifo_wr(lwr), .lfifo_data(ld), .rfifo_wr(rwr), .rfifo_data(rd),
        .irq_ack(ack), .left_level(left_level), .right_level(right_level),
        .frame_strobe(frame_strobe), .left_stat(left_stat), .right_stat(right_stat),
        .mono_stat(mono_stat), .irq(irq), .dreq(dreq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input bit right, input int v);
        @(negedge clk);
        if (right) begin rwr = 1'b1; rd = 12'(v); end
        else       begin lwr = 1'b1; ld = 12'(v); end
        @(negedge clk);
        lwr = 1'b0;
        rwr = 1'b0;
    endtask

    // One period with setting 4, then back to idle; returns at the strobe cycle.
    task automatic step_period();
        @(negedge clk);
        cyc = 12'd4;
        do @(negedge clk); while (!frame_strobe);
        cyc = 12'd1;
    endtask

    task automatic model_push(input bit right, input int v);
        if (!right && cl < 3) begin ql[cl] = v; cl++; end
        if (right && cr < 3)  begin qr[cr] = v; cr++; end
    endtask

    task automatic model_pop(input int src, inout int lvl);
        if (src == 1 && cl > 0) begin
            lvl = ql[0]; ql[0] = ql[1]; ql[1] = ql[2]; cl--;
        end
        if (src == 2 && cr > 0) begin
            lvl = qr[0]; qr[0] = qr[1]; qr[1] = qr[2]; cr--;
        end
    endtask

    task automatic model_fetch(input int lmode, input int rmode);
        int ls, rs;
        ls = (lmode == 1) ? 1 : (lmode == 2) ? 2 : 0;
        rs = (rmode == 1) ? 2 : (rmode == 2) ? 1 : 0;
        if (ls != 0 || rs != 0) begin
            model_pop(ls, exp_l);
            model_pop(rs, exp_r);
            exp_ls = (cl == 0) ? 16384 : 0;
            exp_rs = (cr == 0) ? 16384 : 0;
            exp_ms = (cl == 0 && cr == 0) ? 16384 : 0;
        end
    endtask

    initial begin
        int n, k, strobes, seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 left_level", int'(left_level), 0);
        check("R9 right_level", int'(right_level), 0);
        check("R9 left_stat", int'(left_stat), 16384);
        check("R9 right_stat", int'(right_stat), 16384);
        check("R9 mono_stat", int'(mono_stat), 16384);
        check("R9 irq", int'(irq), 0);
        check("R9 dreq", int'(dreq), 0);
        check("R9 frame_strobe", int'(frame_strobe), 0);

        // R2 idle with cycle setting 1, while filling the left queue past full
        lm = 2'd1;
        for (int i = 1; i <= 5; i++) push(1'b0, i * 100);
        strobes = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (frame_strobe) strobes++;
        end
        check("R2 strobes with unit cycle", strobes, 0);
        check("R2 left_level unchanged", int'(left_level), 0);

        // R7 order and drop of writes 4 and 5
        step_period();
        check("R7 R3 first pop", int'(left_level), 100);
        check("R8 left not empty", int'(left_stat), 0);
        step_period();
        check("R7 second pop", int'(left_level), 200);
        step_period();
        check("R7 third pop", int'(left_level), 300);
        check("R8 left empty", int'(left_stat), 16384);
        check("R8 mono empty", int'(mono_stat), 16384);
        step_period();
        check("R7 R6 empty pop holds", int'(left_level), 300);
        check("R4 right off holds", int'(right_level), 0);
        exp_l = 300;

        // R1 period spacing
        @(negedge clk);
        lm = 2'd0;
        foreach (n_list[i]) begin
            @(negedge clk);
            cyc = 12'(n_list[i]);
            do @(negedge clk); while (!frame_strobe);
            n = 0;
            do begin @(negedge clk); n++; end while (!frame_strobe);
            check("R1 strobe gap", n, (n_list[i] == 0) ? 4095 : n_list[i] - 1);
        end
        @(negedge clk);
        cyc = 12'd1;
        repeat (3) @(negedge clk);

        // R3 R4 R5 R6 R8 mode sweep against the bench queue model
        tmr = 4'd0;
        den = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int kl, kr;
                    kl = (a + b + pass) % 4;
                    kr = (a * 3 + b + 1 + pass) % 4;
                    for (int i = 0; i < kl; i++) begin push(1'b0, seq); model_push(1'b0, seq); seq += 7; end
                    for (int i = 0; i < kr; i++) begin push(1'b1, seq); model_push(1'b1, seq); seq += 7; end
                    @(negedge clk);
                    lm = 2'(a);
                    rm = 2'(b);
                    step_period();
                    model_fetch(a, b);
                    check("R3 R5 R6 left_level", int'(left_level), exp_l);
                    check("R4 R5 R6 right_level", int'(right_level), exp_r);
                    check("R8 left_stat", int'(left_stat), exp_ls);
                    check("R8 right_stat", int'(right_stat), exp_rs);
                    check("R8 mono_stat", int'(mono_stat), exp_ms);
                end
            end
        end

        // R10 R12 timer sweep, reload every clock
        @(negedge clk);
        lm = 2'd1;
        rm = 2'd0;
        den = 1'b1;
        cyc = 12'd2;
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            tmr = 4'(t);
            twr = 1'b1;
            ack = 2'b11;
            @(negedge clk);
            twr = 1'b0;
            ack = 2'b00;
            k = 0;
            while (irq[0] == 1'b0 && k < 40) begin @(negedge clk); k++; end
            check("R10 periods to irq", k, (t == 0) ? 16 : t);
            check("R10 both irq", int'(irq), 3);
            check("R12 dreq pulse", int'(dreq), 3);
            if (t != 1) begin
                @(negedge clk);
                check("R12 dreq one cycle", int'(dreq), 0);
            end
        end

        // R11 per-processor acknowledge
        lm = 2'd0;
        @(negedge clk);
        ack = 2'b01;
        @(negedge clk);
        ack = 2'b00;
        check("R11 ack clears own bit", int'(irq), 2);
        ack = 2'b10;
        @(negedge clk);
        ack = 2'b00;
        check("R11 second ack", int'(irq), 0);

        // R5 inactive modes do not advance the period count
        tmr = 4'd1;
        rm = 2'd3;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq != 2'b00) seen++;
        end
        check("R5 no irq without reload", seen, 0);

        // R13 timer write restarts the count; R12 gate off
        rm = 2'd0;
        lm = 2'd1;
        den = 1'b0;
        tmr = 4'd4;
        twr = 1'b1;
        @(negedge clk);
        twr = 1'b0;
        repeat (2) @(negedge clk);
        twr = 1'b1;
        @(negedge clk);
        twr = 1'b0;
        k = 0;
        while (irq[0] == 1'b0 && k < 40) begin @(negedge clk); k++; end
        check("R13 count restarts", k, 4);
        check("R12 no dreq when disabled", int'(dreq), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int n_list[7] = '{2, 3, 4, 7, 16, 100, 0};

endmodule